// File: doc/BRIEF.md
# PC Card Byte/Word Lane Steering

This block connects a 16-bit removable-card host bus to a bank of flash devices organised in pairs, one device on each byte lane. It decodes the two card-enable strobes, the byte address bit, the read and write strobes and the plane-select input, and produces three groups of outputs:

- the chip select for one device pair;
- separate read and write strobes for the low and high device lanes;
- enables for the two host data lanes.

When an 8-bit host asks for an odd byte through the low card enable, the block moves that byte onto the host's low lane, so a byte-wide host can reach every location. Writes take the reverse path.

A second plane holds the card's identification and configuration bytes. The block reaches it through its own strobes, and on that plane only even bytes exist. A write-protect input blocks writes to the flash array. All host inputs are registered once, so every output reflects the host signals sampled at the previous clock edge.

Top module: `pcard_lane_steer`

## Requirements
- R1: With both ceN inputs high (standby), both host lane enables are 0, hostDataOut is 0, and no chip select, read strobe or write strobe is active, whatever oeN and weN do.
- R2: With ce1N low, ce2N high and hostA0 = 0, the even byte alone moves on host lane bits 7:0 through the low device lane. Host bits 15:8 stay disabled.
- R3: With ce1N low, ce2N high and hostA0 = 1, the odd byte moves on host bits 7:0 through the high device lane. On a write, host bits 7:0 are routed to devDHi.
- R4: With both ceN inputs low, the access is a word: even byte on host bits 7:0, odd byte on host bits 15:8, and hostA0 has no effect.
- R5: With ce1N high and ce2N low, only the odd byte moves, on host bits 15:8. Host bits 7:0 stay disabled.
- R6: A read requires oeN = 0 and weN = 1, and only then are the lane enables driven. A write requires weN = 0 and oeN = 1. With both strobes low, or both high, nothing happens. Disabled host lanes read as 0.
- R7: Word-address bits from PAIR_LSB upward select one pair; at most one pairCsN is low. devAddr carries word-address bits PAIR_LSB-1:1. A selector value of NUM_PAIRS or above selects no device, reads 8'hFF on each enabled lane, and discards writes.
- R8: With wpIn = 1, writes to the common plane (regN = 1) issue no device write strobe and leave the flash contents unchanged. Writes to the attribute plane still take effect.
- R9: With regN = 0, the attribute plane is used through attrCsN/attrRdN/attrWrN, and no flash strobe is issued. Only even bytes exist there, at attrAddr = word-address bits ATTR_AW:1. Odd-byte reads return 8'hFF, and odd-byte writes are ignored.
- R10: Outputs follow the inputs sampled at the previous rising clock edge. While rst is high, the block behaves as in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce1N | input | 1 | Low-lane card enable, active low |
| ce2N | input | 1 | High-lane card enable, active low |
| hostA0 | input | 1 | Byte address bit |
| oeN | input | 1 | Read strobe, active low |
| weN | input | 1 | Write strobe, active low |
| regN | input | 1 | Attribute plane select, active low |
| wpIn | input | 1 | Write protect, active high |
| hostAddr | input | ADDR_W-1 | Word address, bits ADDR_W-1:1 |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data |
| hostLoOe | output | 1 | Drive enable for host bits 7:0 |
| hostHiOe | output | 1 | Drive enable for host bits 15:8 |
| pairCsN | output | NUM_PAIRS | Per-pair chip select, active low |
| devAddr | output | PAIR_LSB-1 | Word address inside a pair |
| devRdLoN | output | 1 | Low device lane read strobe |
| devRdHiN | output | 1 | High device lane read strobe |
| devWrLoN | output | 1 | Low device lane write strobe |
| devWrHiN | output | 1 | High device lane write strobe |
| devDLo | output | 8 | Low device lane write data |
| devDHi | output | 8 | High device lane write data |
| devQLo | input | 8 | Low device lane read data |
| devQHi | input | 8 | High device lane read data |
| attrCsN | output | 1 | Attribute memory select |
| attrRdN | output | 1 | Attribute memory read strobe |
| attrWrN | output | 1 | Attribute memory write strobe |
| attrAddr | output | ATTR_AW | Attribute even-byte index |
| attrD | output | 8 | Attribute write data |
| attrQ | input | 8 | Attribute read data |

## Verification
The bench targets the cases where lane steering goes wrong quietly.

- An odd byte read or written through the low card enable must land on the high device lane. A design that forgot the crossover would return or corrupt the even byte at that address, and the error would only show when the data is read back as a word.
- Word accesses are repeated with hostA0 set, to catch a decoder that lets the byte bit leak into word mode.
- Writes are made to an unpopulated pair slot, under write protect, and to odd attribute bytes. The same locations are then read back, so a design that aliased a pair, ignored protection, or stored an odd attribute byte would expose a changed value.
- Cycles with both strobes low, and standby cycles with a strobe low, must leave the lanes disabled and the contents untouched.

// File: rtl/pcard_lane_pkg.sv
package pcard_lane_pkg;
  // Decoded control for one host cycle, produced by the control stage.
  typedef struct packed {
    logic rd;        // read cycle
    logic wr;        // write cycle
    logic attr;      // attribute plane
    logic devLo;     // even byte involved (low device lane)
    logic devHi;     // odd byte involved (high device lane)
    logic hostLo;    // host bits 7:0 carry data
    logic hostHi;    // host bits 15:8 carry data
    logic swap;      // odd byte crosses to host low lane
    logic pairValid; // address selects a populated pair
    logic wpOn;      // write protect sampled
  } laneCtl_t;

  localparam logic [7:0] NOT_VALID_BYTE = 8'hFF;
endpackage

// File: rtl/pcard_lane_ctl.sv
module pcard_lane_ctl
  import pcard_lane_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int PAIR_LSB  = 17,
  parameter int NUM_PAIRS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce1N,
  input  logic                    ce2N,
  input  logic                    hostA0,
  input  logic                    oeN,
  input  logic                    weN,
  input  logic                    regN,
  input  logic                    wpIn,
  input  logic [ADDR_W-1:1]       hostAddr,
  input  logic [15:0]             hostDataIn,
  output laneCtl_t                ctlQ,
  output logic [$clog2(NUM_PAIRS)-1:0] pairIdxQ,
  output logic [ADDR_W-1:1]       wordAddrQ,
  output logic [15:0]             dataInQ
);
  localparam int SEL_W = ADDR_W - PAIR_LSB;
  localparam int IDX_W = $clog2(NUM_PAIRS);

  laneCtl_t ctlNext;
  logic [SEL_W-1:0] pairSel;
  logic standby, wordAcc, lowOnly, oddOnly;

  assign pairSel = hostAddr[ADDR_W-1:PAIR_LSB];

  always_comb begin
    standby = ce1N & ce2N;
    wordAcc = ~ce1N & ~ce2N;
    lowOnly = ~ce1N & ce2N;
    oddOnly = ce1N & ~ce2N;

    ctlNext           = '0;
    ctlNext.rd        = ~standby & ~oeN & weN;
    ctlNext.wr        = ~standby & ~weN & oeN;
    ctlNext.attr      = ~regN;
    ctlNext.devLo     = wordAcc | (lowOnly & ~hostA0);
    ctlNext.devHi     = wordAcc | (lowOnly & hostA0) | oddOnly;
    ctlNext.hostLo    = wordAcc | lowOnly;
    ctlNext.hostHi    = wordAcc | oddOnly;
    ctlNext.swap      = lowOnly & hostA0;
    ctlNext.pairValid = 32'(pairSel) < NUM_PAIRS;
    ctlNext.wpOn      = wpIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlQ      <= '0;
      pairIdxQ  <= '0;
      wordAddrQ <= '0;
      dataInQ   <= '0;
    end else begin
      ctlQ      <= ctlNext;
      pairIdxQ  <= hostAddr[PAIR_LSB +: IDX_W];
      wordAddrQ <= hostAddr;
      dataInQ   <= hostDataIn;
    end
  end
endmodule

// File: rtl/pcard_lane_dp.sv
module pcard_lane_dp
  import pcard_lane_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int PAIR_LSB  = 17,
  parameter int NUM_PAIRS = 4,
  parameter int ATTR_AW   = 10
) (
  input  laneCtl_t                ctlQ,
  input  logic [$clog2(NUM_PAIRS)-1:0] pairIdxQ,
  input  logic [ADDR_W-1:1]       wordAddrQ,
  input  logic [15:0]             dataInQ,
  output logic [15:0]             hostDataOut,
  output logic                    hostLoOe,
  output logic                    hostHiOe,
  output logic [NUM_PAIRS-1:0]    pairCsN,
  output logic [PAIR_LSB-2:0]     devAddr,
  output logic                    devRdLoN,
  output logic                    devRdHiN,
  output logic                    devWrLoN,
  output logic                    devWrHiN,
  output logic [7:0]              devDLo,
  output logic [7:0]              devDHi,
  input  logic [7:0]              devQLo,
  input  logic [7:0]              devQHi,
  output logic                    attrCsN,
  output logic                    attrRdN,
  output logic                    attrWrN,
  output logic [ATTR_AW-1:0]      attrAddr,
  output logic [7:0]              attrD,
  input  logic [7:0]              attrQ
);
  localparam int IDX_W = $clog2(NUM_PAIRS);

  logic commonRd, commonWr, pairAct;
  logic attrRd, attrWr;
  logic [7:0] evenByte, oddByte;

  assign commonRd = ctlQ.rd & ~ctlQ.attr & ctlQ.pairValid;
  assign commonWr = ctlQ.wr & ~ctlQ.attr & ctlQ.pairValid & ~ctlQ.wpOn;
  assign pairAct  = commonRd | commonWr;

  generate
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pairCs
      assign pairCsN[g] = ~(pairAct && (pairIdxQ == IDX_W'(g)));
    end
  endgenerate

  assign devAddr  = wordAddrQ[PAIR_LSB-1:1];
  assign devRdLoN = ~(commonRd & ctlQ.devLo);
  assign devRdHiN = ~(commonRd & ctlQ.devHi);
  assign devWrLoN = ~(commonWr & ctlQ.devLo);
  assign devWrHiN = ~(commonWr & ctlQ.devHi);
  assign devDLo   = dataInQ[7:0];
  assign devDHi   = ctlQ.swap ? dataInQ[7:0] : dataInQ[15:8];

  // Attribute plane: only the even byte exists.
  assign attrRd   = ctlQ.rd & ctlQ.attr & ctlQ.devLo;
  assign attrWr   = ctlQ.wr & ctlQ.attr & ctlQ.devLo;
  assign attrCsN  = ~(attrRd | attrWr);
  assign attrRdN  = ~attrRd;
  assign attrWrN  = ~attrWr;
  assign attrAddr = wordAddrQ[ATTR_AW:1];
  assign attrD    = dataInQ[7:0];

  always_comb begin
    if (ctlQ.attr) begin
      evenByte = attrQ;
      oddByte  = NOT_VALID_BYTE;
    end else if (ctlQ.pairValid) begin
      evenByte = devQLo;
      oddByte  = devQHi;
    end else begin
      evenByte = NOT_VALID_BYTE;
      oddByte  = NOT_VALID_BYTE;
    end
  end

  assign hostLoOe = ctlQ.rd & ctlQ.hostLo;
  assign hostHiOe = ctlQ.rd & ctlQ.hostHi;
  assign hostDataOut[7:0]  = hostLoOe ? (ctlQ.swap ? oddByte : evenByte) : 8'h00;
  assign hostDataOut[15:8] = hostHiOe ? oddByte : 8'h00;
endmodule

// File: rtl/pcard_lane_steer.sv
module pcard_lane_steer
  import pcard_lane_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int PAIR_LSB  = 17,
  parameter int NUM_PAIRS = 4,
  parameter int ATTR_AW   = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce1N,
  input  logic                 ce2N,
  input  logic                 hostA0,
  input  logic                 oeN,
  input  logic                 weN,
  input  logic                 regN,
  input  logic                 wpIn,
  input  logic [ADDR_W-1:1]    hostAddr,
  input  logic [15:0]          hostDataIn,
  output logic [15:0]          hostDataOut,
  output logic                 hostLoOe,
  output logic                 hostHiOe,
  output logic [NUM_PAIRS-1:0] pairCsN,
  output logic [PAIR_LSB-2:0]  devAddr,
  output logic                 devRdLoN,
  output logic                 devRdHiN,
  output logic                 devWrLoN,
  output logic                 devWrHiN,
  output logic [7:0]           devDLo,
  output logic [7:0]           devDHi,
  input  logic [7:0]           devQLo,
  input  logic [7:0]           devQHi,
  output logic                 attrCsN,
  output logic                 attrRdN,
  output logic                 attrWrN,
  output logic [ATTR_AW-1:0]   attrAddr,
  output logic [7:0]           attrD,
  input  logic [7:0]           attrQ
);
  laneCtl_t ctlQ;
  logic [$clog2(NUM_PAIRS)-1:0] pairIdxQ;
  logic [ADDR_W-1:1] wordAddrQ;
  logic [15:0] dataInQ;

  pcard_lane_ctl #(.ADDR_W(ADDR_W), .PAIR_LSB(PAIR_LSB), .NUM_PAIRS(NUM_PAIRS)) u_ctl (
    .clk(clk), .rst(rst), .ce1N(ce1N), .ce2N(ce2N), .hostA0(hostA0),
    .oeN(oeN), .weN(weN), .regN(regN), .wpIn(wpIn), .hostAddr(hostAddr),
    .hostDataIn(hostDataIn), .ctlQ(ctlQ), .pairIdxQ(pairIdxQ),
    .wordAddrQ(wordAddrQ), .dataInQ(dataInQ)
  );

  pcard_lane_dp #(.ADDR_W(ADDR_W), .PAIR_LSB(PAIR_LSB), .NUM_PAIRS(NUM_PAIRS),
                  .ATTR_AW(ATTR_AW)) u_dp (
    .ctlQ(ctlQ), .pairIdxQ(pairIdxQ), .wordAddrQ(wordAddrQ), .dataInQ(dataInQ),
    .hostDataOut(hostDataOut), .hostLoOe(hostLoOe), .hostHiOe(hostHiOe),
    .pairCsN(pairCsN), .devAddr(devAddr), .devRdLoN(devRdLoN), .devRdHiN(devRdHiN),
    .devWrLoN(devWrLoN), .devWrHiN(devWrHiN), .devDLo(devDLo), .devDHi(devDHi),
    .devQLo(devQLo), .devQHi(devQHi), .attrCsN(attrCsN), .attrRdN(attrRdN),
    .attrWrN(attrWrN), .attrAddr(attrAddr), .attrD(attrD), .attrQ(attrQ)
  );
endmodule

// File: rtl/pcard_lane_chk.sv
module pcard_lane_chk #(
  parameter int NUM_PAIRS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ce1N,
  input logic                 ce2N,
  input logic                 hostA0,
  input logic                 oeN,
  input logic                 weN,
  input logic                 regN,
  input logic                 wpIn,
  input logic                 hostLoOe,
  input logic                 hostHiOe,
  input logic [NUM_PAIRS-1:0] pairCsN,
  input logic                 devRdLoN,
  input logic                 devRdHiN,
  input logic                 devWrLoN,
  input logic                 devWrHiN,
  input logic                 attrWrN
);
  // Set once the previous edge sampled inputs outside reset.
  logic pastOk;
  always_ff @(posedge clk) pastOk <= !rst;

  // R1: standby leaves every lane and strobe idle
  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(ce1N && ce2N)) |->
      (!hostLoOe && !hostHiOe && (&pairCsN) && devWrLoN && devWrHiN && attrWrN));

  // R3: odd byte via low enable reads on the low host lane only
  a_r3_odd_cross: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(!ce1N && ce2N && hostA0 && !oeN && weN)) |->
      (hostLoOe && !hostHiOe && devRdLoN));

  // R4: word read enables both host lanes
  a_r4_word_lanes: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(!ce1N && !ce2N && !oeN && weN)) |-> (hostLoOe && hostHiOe));

  // R6: no lane is driven while a write strobe is active
  a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
    !((hostLoOe || hostHiOe) && (!devWrLoN || !devWrHiN || !attrWrN)));

  // R7: at most one pair selected
  a_r7_one_pair: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~pairCsN));

  // R8: protected common-plane writes issue no flash strobe
  a_r8_wp_block: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(wpIn && regN && !weN)) |-> (devWrLoN && devWrHiN));

  // R9: attribute plane never strobes the flash
  a_r9_attr_no_flash: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(!regN)) |->
      (devRdLoN && devRdHiN && devWrLoN && devWrHiN && (&pairCsN)));
endmodule

bind pcard_lane_steer pcard_lane_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst(rst), .ce1N(ce1N), .ce2N(ce2N), .hostA0(hostA0), .oeN(oeN),
  .weN(weN), .regN(regN), .wpIn(wpIn), .hostLoOe(hostLoOe), .hostHiOe(hostHiOe),
  .pairCsN(pairCsN), .devRdLoN(devRdLoN), .devRdHiN(devRdHiN),
  .devWrLoN(devWrLoN), .devWrHiN(devWrHiN), .attrWrN(attrWrN)
);

// File: tb/pcard_lane_steer_tb.sv
module pcard_lane_steer_tb;
  localparam int ADDR_W = 20, PAIR_LSB = 17, NUM_PAIRS = 4, ATTR_AW = 10;

  logic clk = 0, rst = 1;
  logic ce1N = 1, ce2N = 1, hostA0 = 0, oeN = 1, weN = 1, regN = 1, wpIn = 0;
  logic [ADDR_W-1:1] hostAddr = '0;
  logic [15:0] hostDataIn = '0, hostDataOut;
  logic hostLoOe, hostHiOe;
  logic [NUM_PAIRS-1:0] pairCsN;
  logic [PAIR_LSB-2:0] devAddr;
  logic devRdLoN, devRdHiN, devWrLoN, devWrHiN, attrCsN, attrRdN, attrWrN;
  logic [7:0] devDLo, devDHi, devQLo = 0, devQHi = 0, attrD, attrQ = 0;
  logic [ATTR_AW-1:0] attrAddr;

  always #5 clk = ~clk;

  pcard_lane_steer u_dut (.*);

  int vectors = 0, misses = 0;
  // Device-side byte memories (written only through the DUT strobes)
  logic [7:0] memLo [int];
  logic [7:0] memHi [int];
  logic [7:0] memAttr [int];
  // Reference model keyed by host byte address / attribute word
  logic [7:0] refCom [int];
  logic [7:0] refAttr [int];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] refRead(int word, bit odd, bit attr);
    if (attr) begin
      if (odd) return 8'hFF;
      return refAttr.exists(word % (1 << ATTR_AW)) ? refAttr[word % (1 << ATTR_AW)] : 8'hFF;
    end
    if ((word >> (PAIR_LSB - 1)) >= NUM_PAIRS) return 8'hFF;
    return refCom.exists(word * 2 + int'(odd)) ? refCom[word * 2 + int'(odd)] : 8'hFF;
  endfunction

  task automatic access(string req, logic c1, logic c2, logic a0, logic oe, logic we,
                        logic rg, logic wp, int word, logic [15:0] din);
    bit rd, wr, wAcc, lOnly, oOnly, evIn, odIn, hLo, hHi, sw, attr, valid, expWr, actWr;
    logic [15:0] expOut;
    int sel;
    @(negedge clk);
    ce1N = c1; ce2N = c2; hostA0 = a0; oeN = oe; weN = we; regN = rg; wpIn = wp;
    hostAddr = (ADDR_W-1)'(word); hostDataIn = din;
    @(posedge clk);
    #1;
    sel = -1;
    for (int p = 0; p < NUM_PAIRS; p++) if (!pairCsN[p]) sel = p;
    devQLo = (sel >= 0 && !devRdLoN && memLo.exists(sel * 65536 + int'(devAddr))) ?
             memLo[sel * 65536 + int'(devAddr)] : 8'hFF;
    devQHi = (sel >= 0 && !devRdHiN && memHi.exists(sel * 65536 + int'(devAddr))) ?
             memHi[sel * 65536 + int'(devAddr)] : 8'hFF;
    attrQ  = (!attrRdN && memAttr.exists(int'(attrAddr))) ? memAttr[int'(attrAddr)] : 8'hFF;
    @(negedge clk);
    // Expected behaviour from the requirements
    rd = !oe && we && !(c1 && c2);
    wr = !we && oe && !(c1 && c2);
    wAcc = !c1 && !c2; lOnly = !c1 && c2; oOnly = c1 && !c2;
    evIn = wAcc || (lOnly && !a0);
    odIn = wAcc || (lOnly && a0) || oOnly;
    hLo = wAcc || lOnly; hHi = wAcc || oOnly; sw = lOnly && a0;
    attr = !rg;
    valid = (word >> (PAIR_LSB - 1)) < NUM_PAIRS;
    expOut = '0;
    if (rd && hLo) expOut[7:0] = refRead(word, sw, attr);
    if (rd && hHi) expOut[15:8] = refRead(word, 1'b1, attr);
    chk(req, "hostLoOe", 16'(hostLoOe), 16'(rd && hLo));
    chk(req, "hostHiOe", 16'(hostHiOe), 16'(rd && hHi));
    chk(req, "hostDataOut", hostDataOut, expOut);
    expWr = wr && ((attr && evIn) || (!attr && valid && !wp));
    actWr = !devWrLoN || !devWrHiN || !attrWrN;
    chk(req, "write strobe", 16'(actWr), 16'(expWr));
    // Device models capture what the DUT strobes
    if (sel >= 0 && !devWrLoN) memLo[sel * 65536 + int'(devAddr)] = devDLo;
    if (sel >= 0 && !devWrHiN) memHi[sel * 65536 + int'(devAddr)] = devDHi;
    if (!attrWrN) memAttr[int'(attrAddr)] = attrD;
    // Reference update
    if (wr && attr && evIn) refAttr[word % (1 << ATTR_AW)] = din[7:0];
    if (wr && !attr && valid && !wp) begin
      if (evIn) refCom[word * 2] = din[7:0];
      if (odIn) refCom[word * 2 + 1] = sw ? din[7:0] : din[15:8];
    end
  endtask

  // convenience wrappers: c1,c2,a0,oe,we,reg,wp
  task automatic wrWord(string r, int w, logic [15:0] d, logic rg = 1, logic wp = 0);
    access(r, 0, 0, 0, 1, 0, rg, wp, w, d);
  endtask
  task automatic rdWord(string r, int w, logic a0 = 0, logic rg = 1);
    access(r, 0, 0, a0, 0, 1, rg, 0, w, 16'h0);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state is standby
    chk("R10", "reset lanes", {14'd0, hostLoOe, hostHiOe}, 16'd0);
    chk("R10", "reset strobes", {10'd0, pairCsN, devWrLoN, devWrHiN}, {10'd0, 4'hF, 2'b11});
    oeN = 0; oeN = 1;
    rst = 0;

    // R4, R7: word writes to every populated pair, read back, A0 ignored
    for (int p = 0; p < NUM_PAIRS; p++) begin
      wrWord("R7", p * 65536 + 16'h0123 + p, 16'hA050 + 16'(p * 16'h1111));
      rdWord("R4", p * 65536 + 16'h0123 + p, 1'b1);
      rdWord("R7", p * 65536 + 16'h0123 + p, 1'b0);
    end
    access("R4", 0, 0, 1, 1, 0, 1, 0, 40, 16'hBEEF);   // word write with A0 high
    rdWord("R4", 40);
    // R2: even byte on low lane
    access("R2", 0, 1, 0, 1, 0, 1, 0, 50, 16'hEE11);
    access("R2", 0, 1, 0, 0, 1, 1, 0, 50, 16'h0);
    // R3: odd byte crosses to low lane
    access("R3", 0, 1, 1, 1, 0, 1, 0, 50, 16'h7722);
    access("R3", 0, 1, 1, 0, 1, 1, 0, 50, 16'h0);
    rdWord("R3", 50);
    // R5: odd-only on high lane
    access("R5", 1, 0, 0, 1, 0, 1, 0, 51, 16'h3300);
    access("R5", 1, 0, 1, 0, 1, 1, 0, 51, 16'h0);
    rdWord("R5", 51);
    // R1: standby with strobes low does nothing
    access("R1", 1, 1, 0, 0, 1, 1, 0, 40, 16'h0);
    access("R1", 1, 1, 0, 1, 0, 1, 0, 40, 16'h1234);
    rdWord("R1", 40);
    // R6: both strobes low, both high
    access("R6", 0, 0, 0, 0, 0, 1, 0, 40, 16'h5555);
    access("R6", 0, 0, 0, 1, 1, 1, 0, 40, 16'h6666);
    rdWord("R6", 40);
    // R7: unpopulated slots
    wrWord("R7", 5 * 65536 + 7, 16'hC3C3);
    rdWord("R7", 5 * 65536 + 7);
    rdWord("R7", 7 * 65536 + 9);
    // R8: write protect blocks flash, not attribute
    wrWord("R8", 2 * 65536 + 0, 16'hDEAD, 1, 1);
    rdWord("R8", 2 * 65536 + 0);
    access("R8", 0, 1, 1, 1, 0, 1, 1, 50, 16'h0099);
    rdWord("R8", 50);
    wrWord("R8", 12, 16'h00A5, 0, 1);
    rdWord("R8", 12, 0, 0);
    // R9: attribute plane
    wrWord("R9", 3, 16'h9A5C, 0);
    rdWord("R9", 3, 0, 0);
    access("R9", 0, 1, 0, 0, 1, 0, 0, 3, 16'h0);
    access("R9", 0, 1, 1, 1, 0, 0, 0, 3, 16'h0077);
    access("R9", 0, 1, 1, 0, 1, 0, 0, 3, 16'h0);
    access("R9", 1, 0, 0, 1, 0, 0, 0, 4, 16'h6600);
    access("R9", 1, 0, 0, 0, 1, 0, 0, 4, 16'h0);
    rdWord("R9", 3, 1, 0);
    rdWord("R9", 4, 0, 0);
    // Mixed sweep over the lane patterns
    for (int i = 0; i < 24; i++) begin
      access("R4", logic'(i[0]), logic'(i[1]), logic'(i[2]), 1, 0, 1, 0,
             (i % 3) * 65536 + 200 + i / 8, 16'(i * 16'h0A17));
      access("R2", logic'(i[0]), logic'(i[1]), logic'(i[2]), 0, 1, 1, 0,
             (i % 3) * 65536 + 200 + i / 8, 16'h0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule